// File: doc/BRIEF.md
# Serial-Programmed Stereo Volume Control

This block is the digital control side of a two-channel stepped attenuator. A host writes 16-bit command words over a chip-select-framed serial port (select, serial clock, serial data). Each word carries one 8-bit attenuation code per channel. Each code is a step count of 0.5 dB, and code 0 is mute. While select is low, the port shifts the bits held in its 16-bit register out of a serial output pin. Several blocks can therefore be chained, each one passing the previous frame to its neighbour.

Every channel keeps a pending code and an active code. With zero-cross mode off, a write becomes active at once. With it on, the write waits until that channel's sign input changes. If no crossing comes within a bounded number of cycles, a timeout applies the write anyway. A power-up hold input blanks the port while the analog reference settles. During that time it forces both channels to mute.

All serial pins are sampled by the system clock through synchronizers, so the serial clock must be much slower than the system clock.

Top module: `stereo_vol_ctrl`

## Requirements
- R1: After reset, both gain codes are 0, `mute_o` is 1 and `sdo_oe_o` is 0.
- R2: A frame is shifted MSB first on serial clock rising edges while select is low. Bits 15..8 are the left code and bits 7..0 are the right code. With zero-cross mode off, the codes reach the gain outputs within a few cycles of select rising.
- R3: A frame whose clock count is zero or not a multiple of 16 is discarded, and both gains stay unchanged.
- R4: A frame of 32 clocks is accepted, and the last 16 bits shifted in are used.
- R5: While select is low, `sdo_oe_o` is 1. `sdo_o` first presents the 16 bits held in the shift register before the frame, MSB first, and then the bits of the current frame. It advances after each serial clock falling edge. While select is high, `sdo_oe_o` is 0.
- R6: With zero-cross mode on, a written code stays pending until that channel's sign input changes, and each channel moves independently.
- R7: With zero-cross mode on and no crossing, the pending code is applied after `TIMEOUT_CYC` cycles, and not before.
- R8: A new write that arrives while a code is pending replaces the pending code.
- R9: If zero-cross mode is switched off while a code is pending, the code is applied at once.
- R10: While the hold input is high, both gains are 0, any pending code is dropped, and serial traffic is ignored. The shift register is cleared.
- R11: `mute_o` is 1 exactly when both active codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_i | input | 1 | Power-up hold: blanks the port and forces mute |
| zc_en_i | input | 1 | 1 = apply writes at zero crossing, 0 = apply at once |
| sign_l_i | input | 1 | Left channel sign or comparator output (asynchronous) |
| sign_r_i | input | 1 | Right channel sign or comparator output (asynchronous) |
| csn_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, to the next block in the chain |
| sdo_oe_o | output | 1 | Output enable for the serial data out pad |
| gain_l_o | output | 8 | Active left code (0 = mute, +0.5 dB per step) |
| gain_r_o | output | 8 | Active right code |
| mute_o | output | 1 | Both channels muted |

## Verification
The hardest situation to reach is a pending write that is replaced, timed out or dropped before any crossing arrives. A full frame lasts longer than a short timeout, so the bench sets the timeout well above one frame time. It then sends a second frame while the first is still waiting. It holds the sign inputs still across a long quiet window. It also raises hold while a code is pending. After each of these steps, the bench toggles the signs and confirms at the gain outputs which code, if any, came through. The daisy-chain output is scored bit by bit against a bench model of the shift register, including partial frames and the clear caused by hold.

// File: rtl/svc_pkg.sv
// Package: shared sizes and types for the stereo volume control.
// Assumes two channels of 8-bit codes packed into one frame, left first.
package svc_pkg;
    localparam int CODE_W     = 8;
    localparam int NUM_CH     = 2;
    localparam int FRAME_BITS = NUM_CH * CODE_W;

    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/svc_sync.sv
// Module: multi-stage synchronizer for asynchronous inputs.
// Assumes STAGES >= 2 and that the inputs change far slower than clk.
module svc_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    // Shift the asynchronous sample through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/svc_serial_rx.sv
// Module: chip-select-framed serial receiver with pass-through output.
// Samples select, serial clock and data with clk. Shifts on serial clock
// rising edges and drives out on falling edges. At select rising it
// accepts the frame if a non-zero multiple of FRAME_BITS clocks arrived.
// Assumes each serial clock phase lasts several clk cycles.
module svc_serial_rx #(
    parameter int FRAME_BITS  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hold_i,
    input  logic                  csn_i,
    input  logic                  sclk_i,
    input  logic                  sdi_i,
    output logic                  load_o,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  sdo_o,
    output logic                  sdo_oe_o
);
    localparam int CNT_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

    logic [2:0]            pins_s;
    logic                  cs_s, sck_s, sdi_s;
    logic                  cs_prev_q, sck_prev_q;
    logic                  cs_fall, cs_rise, sck_rise, sck_fall;
    logic                  armed_q, full_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] shift_q, frame_q;
    logic                  load_q, sdo_q, oe_q;

    svc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({csn_i, sclk_i, sdi_i}),
        .q_o   (pins_s)
    );
    assign {cs_s, sck_s, sdi_s} = pins_s;

    // Keep the previous sampled levels for edge detection, even during hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q  <= 1'b1;
            sck_prev_q <= 1'b0;
        end else begin
            cs_prev_q  <= cs_s;
            sck_prev_q <= sck_s;
        end
    end

    assign cs_fall  =  cs_prev_q & ~cs_s;
    assign cs_rise  = ~cs_prev_q &  cs_s;
    assign sck_rise = ~sck_prev_q &  sck_s & ~cs_s;
    assign sck_fall =  sck_prev_q & ~sck_s & ~cs_s;

    // Frame state: arm on select fall, shift and count bits, note a full word.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            armed_q <= 1'b0;
            full_q  <= 1'b0;
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (cs_fall) begin
            armed_q <= 1'b1;
            full_q  <= 1'b0;
            cnt_q   <= '0;
        end else if (cs_rise) begin
            armed_q <= 1'b0;
        end else if (sck_rise && armed_q) begin
            shift_q <= {shift_q[FRAME_BITS-2:0], sdi_s};
            cnt_q   <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) full_q <= 1'b1;
        end
    end

    // Accept strobe and captured word at select rise on a whole-frame count.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            load_q  <= 1'b0;
            frame_q <= '0;
        end else begin
            load_q <= cs_rise && armed_q && full_q && (cnt_q == '0);
            if (cs_rise && armed_q && full_q && (cnt_q == '0)) frame_q <= shift_q;
        end
    end

    // Pass-through output: present the register MSB at select fall and after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            sdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= ~cs_s;
            if (cs_fall || (sck_fall && armed_q)) sdo_q <= shift_q[FRAME_BITS-1];
        end
    end

    assign load_o   = load_q;
    assign frame_o  = frame_q;
    assign sdo_o    = sdo_q;
    assign sdo_oe_o = oe_q;

    // R5: the output bit moves only on select fall or a serial clock fall.
    assert_sdo_stable_R5: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
        (!cs_fall && !sck_fall) |=> $stable(sdo_q));

    // R10: hold leaves the port idle, un-armed and with its output off.
    assert_held_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (!armed_q && !oe_q && cnt_q == '0 && !load_q));

    // R3: a word is only accepted from an armed frame.
    assert_load_needs_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> $past(armed_q));
endmodule

// File: rtl/svc_zc_channel.sv
// Module: one channel's pending/active code pair with zero-cross apply.
// A write is applied at once when zero-cross mode is off. Otherwise it is
// applied at the next change of the synchronized sign input, or after
// TIMEOUT_CYC cycles. Hold or reset mutes the channel and drops any pending code.
// Assumes the sign input comes from an asynchronous comparator.
module svc_zc_channel #(
    parameter int CODE_W      = 8,
    parameter int TIMEOUT_CYC = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              zc_en_i,
    input  logic              sign_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] gain_o
);
    localparam int TMR_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

    logic              sign_s, sign_prev_q, crossing;
    logic              pend_q;
    logic [CODE_W-1:0] pcode_q, active_q;
    logic [TMR_W-1:0]  timer_q;

    svc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sign_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sign_i),
        .q_o   (sign_s)
    );

    // Remember the previous sign so that any change marks a crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) sign_prev_q <= 1'b0;
        else        sign_prev_q <= sign_s;
    end

    assign crossing = sign_s ^ sign_prev_q;

    // Pending/active update: a write takes priority, then the apply of a pending code.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            active_q <= '0;
            pcode_q  <= '0;
            pend_q   <= 1'b0;
            timer_q  <= '0;
        end else if (load_i) begin
            if (zc_en_i) begin
                pcode_q <= code_i;
                pend_q  <= 1'b1;
                timer_q <= '0;
            end else begin
                active_q <= code_i;
                pend_q   <= 1'b0;
            end
        end else if (pend_q) begin
            if (!zc_en_i || crossing || timer_q == TMR_LAST) begin
                active_q <= pcode_q;
                pend_q   <= 1'b0;
            end else begin
                timer_q <= timer_q + 1'b1;
            end
        end
    end

    assign gain_o = active_q;

    // R6: the active code changes only because of a write, a pending apply or hold.
    assert_change_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q != $past(active_q)) |-> ($past(load_i) || $past(pend_q) || $past(hold_i)));

    // R7: the wait counter never passes the timeout limit.
    assert_timer_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (timer_q <= TMR_LAST));

    // R9: leaving zero-cross mode applies the pending code on the next edge.
    assert_apply_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !zc_en_i && !load_i && !hold_i) |=> (!pend_q && active_q == $past(pcode_q)));
endmodule

// File: rtl/stereo_vol_ctrl.sv
// Module: top of the stereo volume control.
// Joins the serial receiver to one zero-cross channel per output. Channel 0
// (left) takes the upper code of the frame. Assumes a synchronous
// active-low reset and asynchronous serial and sign pins.
module stereo_vol_ctrl
    import svc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              zc_en_i,
    input  logic              sign_l_i,
    input  logic              sign_r_i,
    input  logic              csn_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [CODE_W-1:0] gain_l_o,
    output logic [CODE_W-1:0] gain_r_o,
    output logic              mute_o
);
    logic                  load;
    logic [FRAME_BITS-1:0] frame;
    logic [NUM_CH-1:0]     sign_vec;
    code_t                 gain_vec [NUM_CH];

    svc_serial_rx #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (hold_i),
        .csn_i    (csn_i),
        .sclk_i   (sclk_i),
        .sdi_i    (sdi_i),
        .load_o   (load),
        .frame_o  (frame),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe_o)
    );

    assign sign_vec = {sign_r_i, sign_l_i};

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        svc_zc_channel #(
            .CODE_W      (CODE_W),
            .TIMEOUT_CYC (TIMEOUT_CYC),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold_i  (hold_i),
            .zc_en_i (zc_en_i),
            .sign_i  (sign_vec[gi]),
            .load_i  (load),
            .code_i  (frame[FRAME_BITS-1-gi*CODE_W -: CODE_W]),
            .gain_o  (gain_vec[gi])
        );
    end

    assign gain_l_o = gain_vec[0];
    assign gain_r_o = gain_vec[1];
    assign mute_o   = (gain_l_o == '0) && (gain_r_o == '0);

    // R10: one edge with hold high leaves both outputs muted.
    assert_mute_after_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (gain_l_o == '0 && gain_r_o == '0 && mute_o));

    // R1: the edge after reset shows both channels muted.
    assert_reset_mute_R1: assert property (@(posedge clk)
        !rst_n |=> (gain_l_o == '0 && gain_r_o == '0));
endmodule

// File: tb/test_stereo_vol_ctrl.sv
// Bench: scoreboard for the daisy-chain output plus direct gain checks.
module test_stereo_vol_ctrl;
    localparam int TMO = 600;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0, zc_en = 1'b0;
    logic sign_l = 1'b0, sign_r = 1'b0;
    logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe, mute;
    logic [7:0] gain_l, gain_r;

    int n_chk = 0, n_bad = 0;
    bit exp_q[$];
    logic [15:0] sr_model = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stereo_vol_ctrl #(.TIMEOUT_CYC(TMO)) i_stereo_vol_ctrl (
        .clk(clk), .rst_n(rst_n), .hold_i(hold), .zc_en_i(zc_en),
        .sign_l_i(sign_l), .sign_r_i(sign_r), .csn_i(csn), .sclk_i(sclk),
        .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .gain_l_o(gain_l),
        .gain_r_o(gain_r), .mute_o(mute)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: sends n bits MSB first and pushes the expected pass-through stream.
    task automatic send(input logic [31:0] data, input int n);
        @(negedge clk);
        csn = 1'b0;
        if (!hold) begin
            for (int i = 0; i < n; i++) begin
                if (i < 16) exp_q.push_back(sr_model[15-i]);
                else        exp_q.push_back(data[n-1-(i-16)]);
            end
        end
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            sdi = data[n-1-i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
            if (!hold) sr_model = {sr_model[14:0], data[n-1-i]};
        end
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(12);
    endtask

    // Monitor: R5 pass-through bit and output enable at each serial rising edge.
    always @(posedge sclk) begin
        if (!csn && !hold) begin
            if (exp_q.size() == 0) begin
                chk("R5 queue underflow", 32'd1, 32'd0);
            end else begin
                chk("R5 sdo bit", {31'd0, sdo}, {31'd0, exp_q.pop_front()});
                chk("R5 sdo_oe low select", {31'd0, sdo_oe}, 32'd1);
            end
        end
    end

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset state
        chk("R1 gain_l", gain_l, 0);
        chk("R1 gain_r", gain_r, 0);
        chk("R1 mute", mute, 1);
        chk("R1 sdo_oe", sdo_oe, 0);

        // R2 direct write, left upper byte
        send(32'hA05F, 16);
        chk("R2 gain_l", gain_l, 8'hA0);
        chk("R2 gain_r", gain_r, 8'h5F);
        chk("R11 mute off", mute, 0);
        chk("R5 sdo_oe high select", sdo_oe, 0);

        // R3 short and empty frames discarded
        send(32'h0ABC, 12);
        chk("R3 short l", gain_l, 8'hA0);
        chk("R3 short r", gain_r, 8'h5F);
        send(32'h0, 0);
        chk("R3 empty l", gain_l, 8'hA0);
        send(32'h3333, 17);
        chk("R3 17 bits r", gain_r, 8'h5F);

        // R4 double-length frame keeps the last word
        send(32'h1234_8001, 32);
        chk("R4 gain_l", gain_l, 8'h80);
        chk("R4 gain_r", gain_r, 8'h01);

        // R6 zero-cross per channel
        zc_en = 1'b1;
        send(32'h4020, 16);
        chk("R6 waits l", gain_l, 8'h80);
        chk("R6 waits r", gain_r, 8'h01);
        sign_l = 1'b1;
        wait_clk(10);
        chk("R6 left crossed", gain_l, 8'h40);
        chk("R6 right still", gain_r, 8'h01);
        sign_r = 1'b1;
        wait_clk(10);
        chk("R6 right crossed", gain_r, 8'h20);

        // R8 second write replaces pending code
        send(32'h1111, 16);
        send(32'h2222, 16);
        chk("R8 still old", gain_l, 8'h40);
        sign_l = 1'b0; sign_r = 1'b0;
        wait_clk(10);
        chk("R8 replaced l", gain_l, 8'h22);
        chk("R8 replaced r", gain_r, 8'h22);

        // R7 timeout without crossing
        send(32'h3344, 16);
        wait_clk(300);
        chk("R7 not early", gain_l, 8'h22);
        wait_clk(400);
        chk("R7 timeout l", gain_l, 8'h33);
        chk("R7 timeout r", gain_r, 8'h44);

        // R9 leaving zero-cross mode applies at once
        send(32'h5566, 16);
        chk("R9 pending", gain_l, 8'h33);
        zc_en = 1'b0;
        wait_clk(6);
        chk("R9 applied l", gain_l, 8'h55);
        chk("R9 applied r", gain_r, 8'h66);

        // R10 hold mutes, ignores traffic, clears register
        hold = 1'b1;
        wait_clk(4);
        chk("R10 muted l", gain_l, 0);
        chk("R10 mute flag", mute, 1);
        send(32'h7777, 16);
        hold = 1'b0;
        sr_model = '0;
        wait_clk(10);
        chk("R10 ignored", gain_l, 0);
        send(32'h0102, 16);
        chk("R10 after release l", gain_l, 8'h01);
        chk("R10 after release r", gain_r, 8'h02);
        zc_en = 1'b1;
        send(32'h9999, 16);
        hold = 1'b1;
        wait_clk(4);
        hold = 1'b0;
        sr_model = '0;
        sign_l = 1'b1; sign_r = 1'b1;
        wait_clk(10);
        chk("R10 pending dropped", gain_l, 0);
        zc_en = 1'b0;

        // R11 mute flag follows both codes
        send(32'h0001, 16);
        chk("R11 one nonzero", mute, 0);
        send(32'h0000, 16);
        chk("R11 both zero", mute, 1);

        chk("R5 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule